// File: doc/BRIEF.md
# Wake and Runtime Interrupt Router

This block sits beside an infrared receiver peripheral and turns its raw event lines into system interrupts on two independent paths. On the wake path, a wake pulse from the decoder is accepted only while the peripheral is powered, enabled and set to one of the two remote-control decode modes. An accepted pulse latches a sticky wake status. The wake request output is raised while that status is set and both the peripheral-level wake enable and the global wake enable are on.

On the runtime path, any individual event whose own enable bit is set counts as a runtime event, but only while the master interrupt enable is on. A runtime event latches a sticky runtime status. That status can drive an active-low management interrupt output, which is gated by its own enable and by a global pin enable. The same status also drives one line of a one-hot interrupt channel vector, chosen by a channel select value. The management output and the channel line can be active at the same time.

Each status is a two-state machine with the states ST_IDLE and ST_PEND. Transition T_SET moves ST_IDLE to ST_PEND when a qualified event arrives. Transition T_CLEAR moves ST_PEND to ST_IDLE when software writes a one to the clear input and no event arrives in the same cycle. In every other case the state holds (T_HOLD). All outputs are registered from the next state together with the enables, so every output follows its inputs by exactly one clock.

Top module: `irq_event_router`

## Requirements
- R1: After reset, wake_req is 0, mgmt_irq_n is 1 and irq_chan is all zeros, and both statuses are in ST_IDLE.
- R2: A wake pulse is ignored unless periph_powered and periph_enabled are both 1 in the same cycle. An ignored pulse leaves no latched status behind.
- R3: A wake pulse is accepted only when rx_mode is 2'b01 (pulse-position mode) or 2'b10 (bi-phase RC5 mode). The values 2'b00 and 2'b11 are ignored.
- R4: wake_req is 1 exactly when, in the previous cycle, the wake status (after that cycle's update) was ST_PEND and both wake_en and wake_global_en were 1.
- R5: A runtime event occurs only in a cycle where master_irq_en is 1 and at least one bit of evt_status is 1 while the same bit of evt_enable is 1.
- R6: mgmt_irq_n is driven to 0 exactly when, in the previous cycle, the runtime status was ST_PEND and both mgmt_en and mgmt_pin_en were 1. Otherwise it is 1.
- R7: While the runtime status is ST_PEND, irq_chan has bit chan_sel-1 set and all other bits clear. A chan_sel of 0, or a runtime status of ST_IDLE, gives all zeros. The output is registered one clock after chan_sel.
- R8: Each status is sticky. It stays ST_PEND until a one is written to its clear input (wake_sts_clr or run_sts_clr). If a qualified event and a clear arrive in the same cycle, the event wins and the status stays ST_PEND.
- R9: The management interrupt and the selected channel line are driven from the same runtime status, so they can be active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_powered | input | 1 | Peripheral has power |
| periph_enabled | input | 1 | Peripheral is enabled |
| rx_mode | input | 2 | Receive mode: 01 pulse-position, 10 RC5, other values do not wake |
| wake_evt | input | 1 | Wake pulse from the decoder |
| evt_status | input | NUM_EVENTS | Individual event status lines |
| evt_enable | input | NUM_EVENTS | Per-event enables |
| master_irq_en | input | 1 | Master interrupt enable |
| wake_sts_clr | input | 1 | Write-one clear of the wake status |
| wake_en | input | 1 | Peripheral-level wake enable |
| wake_global_en | input | 1 | Global wake enable |
| run_sts_clr | input | 1 | Write-one clear of the runtime status |
| mgmt_en | input | 1 | Runtime-to-management interrupt enable |
| mgmt_pin_en | input | 1 | Global management interrupt pin enable |
| chan_sel | input | CHAN_SEL_W | Interrupt channel select, 0 = no channel |
| wake_req | output | 1 | Wake request |
| mgmt_irq_n | output | 1 | Management interrupt, active low |
| irq_chan | output | NUM_CHAN | One-hot interrupt channel vector |

## Verification
The hardest case to reach from the ports is a qualified event and a clear arriving in the same cycle. The status is only visible through the gated outputs, so the stimulus first latches the status with the output enables held on. It then raises the event and the clear together for a single cycle, and afterwards checks that the output stays active across several cycles. A separate clear-only write must then drop the output. The proof that rejected wake pulses latch nothing follows the same pattern: all output enables stay on, so any stray latch would show one clock later and on every following clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_PPM = 2'b01;
    localparam logic [MODE_W-1:0] MODE_RC5 = 2'b10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } sticky_state_t;
endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_next_o
);
    sticky_state_t state_q;
    sticky_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_SET, T_CLEAR, otherwise T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (set_i) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (clr_i && !set_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pend_next_o = (state_d == ST_PEND);
endmodule

// File: rtl/irq_wake_path.sv
module irq_wake_path
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              powered_i,
    input  logic              enabled_i,
    input  logic [MODE_W-1:0] rx_mode_i,
    input  logic              wake_evt_i,
    input  logic              clr_i,
    input  logic              wake_en_i,
    input  logic              global_en_i,
    output logic              wake_req_o
);
    logic mode_ok;
    logic evt_ok;
    logic pend_next;

    assign mode_ok = (rx_mode_i == MODE_PPM) || (rx_mode_i == MODE_RC5);
    assign evt_ok  = wake_evt_i && powered_i && enabled_i && mode_ok;

    irq_sticky_status i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (evt_ok),
        .clr_i       (clr_i),
        .pend_next_o (pend_next)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_req_o <= 1'b0;
        end else begin
            wake_req_o <= pend_next && wake_en_i && global_en_i;
        end
    end
endmodule

// File: rtl/irq_runtime_path.sv
module irq_runtime_path #(
    parameter int NUM_EVENTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_status_i,
    input  logic [NUM_EVENTS-1:0] evt_enable_i,
    input  logic                  master_en_i,
    input  logic                  clr_i,
    input  logic                  mgmt_en_i,
    input  logic                  pin_en_i,
    output logic                  mgmt_irq_n_o,
    output logic                  pend_next_o
);
    logic evt_ok;

    assign evt_ok = master_en_i && (|(evt_status_i & evt_enable_i));

    irq_sticky_status i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (evt_ok),
        .clr_i       (clr_i),
        .pend_next_o (pend_next_o)
    );

    // output register, active low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mgmt_irq_n_o <= 1'b1;
        end else begin
            mgmt_irq_n_o <= !(pend_next_o && mgmt_en_i && pin_en_i);
        end
    end
endmodule

// File: rtl/irq_chan_route.sv
module irq_chan_route #(
    parameter int NUM_CHAN   = 15,
    parameter int CHAN_SEL_W = $clog2(NUM_CHAN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pend_i,
    input  logic [CHAN_SEL_W-1:0] chan_sel_i,
    output logic [NUM_CHAN-1:0]   irq_chan_o
);
    logic [NUM_CHAN-1:0] chan_d;

    // channel k+1 drives line k; select value 0 drives nothing
    for (genvar k = 0; k < NUM_CHAN; k++) begin : g_line
        assign chan_d[k] = pend_i && (chan_sel_i == CHAN_SEL_W'(k + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_chan_o <= '0;
        end else begin
            irq_chan_o <= chan_d;
        end
    end
endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
    import irq_router_pkg::*;
#(
    parameter int NUM_EVENTS = 4,
    parameter int NUM_CHAN   = 15,
    localparam int CHAN_SEL_W = $clog2(NUM_CHAN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  periph_powered,
    input  logic                  periph_enabled,
    input  logic [MODE_W-1:0]     rx_mode,
    input  logic                  wake_evt,
    input  logic [NUM_EVENTS-1:0] evt_status,
    input  logic [NUM_EVENTS-1:0] evt_enable,
    input  logic                  master_irq_en,
    input  logic                  wake_sts_clr,
    input  logic                  wake_en,
    input  logic                  wake_global_en,
    input  logic                  run_sts_clr,
    input  logic                  mgmt_en,
    input  logic                  mgmt_pin_en,
    input  logic [CHAN_SEL_W-1:0] chan_sel,
    output logic                  wake_req,
    output logic                  mgmt_irq_n,
    output logic [NUM_CHAN-1:0]   irq_chan
);
    logic run_pend_next;

    irq_wake_path i_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .powered_i   (periph_powered),
        .enabled_i   (periph_enabled),
        .rx_mode_i   (rx_mode),
        .wake_evt_i  (wake_evt),
        .clr_i       (wake_sts_clr),
        .wake_en_i   (wake_en),
        .global_en_i (wake_global_en),
        .wake_req_o  (wake_req)
    );

    irq_runtime_path #(
        .NUM_EVENTS (NUM_EVENTS)
    ) i_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_status_i (evt_status),
        .evt_enable_i (evt_enable),
        .master_en_i  (master_irq_en),
        .clr_i        (run_sts_clr),
        .mgmt_en_i    (mgmt_en),
        .pin_en_i     (mgmt_pin_en),
        .mgmt_irq_n_o (mgmt_irq_n),
        .pend_next_o  (run_pend_next)
    );

    irq_chan_route #(
        .NUM_CHAN   (NUM_CHAN),
        .CHAN_SEL_W (CHAN_SEL_W)
    ) i_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (run_pend_next),
        .chan_sel_i (chan_sel),
        .irq_chan_o (irq_chan)
    );
endmodule

// File: rtl/irq_event_router_chk.sv
module irq_event_router_chk #(
    parameter int NUM_CHAN   = 15,
    parameter int CHAN_SEL_W = $clog2(NUM_CHAN + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wake_sts_clr,
    input logic                  wake_en,
    input logic                  wake_global_en,
    input logic                  run_sts_clr,
    input logic                  mgmt_en,
    input logic                  mgmt_pin_en,
    input logic [CHAN_SEL_W-1:0] chan_sel,
    input logic                  wake_req,
    input logic                  mgmt_irq_n,
    input logic [NUM_CHAN-1:0]   irq_chan
);
    a_r4_wake_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(wake_en && wake_global_en));

    a_r6_mgmt_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_irq_n |-> $past(mgmt_en && mgmt_pin_en));

    a_r7_chan_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_chan));

    a_r7_chan_none_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_sel) == '0) |-> (irq_chan == '0));

    a_r8_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_sts_clr && wake_en && wake_global_en) |=> wake_req);

    a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_irq_n && !run_sts_clr && mgmt_en && mgmt_pin_en) |=> !mgmt_irq_n);

    a_r9_chan_with_mgmt: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_chan != '0) && $past(mgmt_en && mgmt_pin_en)) |-> !mgmt_irq_n);
endmodule

bind irq_event_router irq_event_router_chk #(
    .NUM_CHAN (NUM_CHAN)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wake_sts_clr   (wake_sts_clr),
    .wake_en        (wake_en),
    .wake_global_en (wake_global_en),
    .run_sts_clr    (run_sts_clr),
    .mgmt_en        (mgmt_en),
    .mgmt_pin_en    (mgmt_pin_en),
    .chan_sel       (chan_sel),
    .wake_req       (wake_req),
    .mgmt_irq_n     (mgmt_irq_n),
    .irq_chan       (irq_chan)
);

// File: tb/test_irq_event_router.sv
`timescale 1ns/100ps
module test_irq_event_router;
    localparam int NE = 4;
    localparam int NC = 15;
    localparam int SW = $clog2(NC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          periph_powered = 1'b0;
    logic          periph_enabled = 1'b0;
    logic [1:0]    rx_mode = 2'b00;
    logic          wake_evt = 1'b0;
    logic [NE-1:0] evt_status = '0;
    logic [NE-1:0] evt_enable = '0;
    logic          master_irq_en = 1'b0;
    logic          wake_sts_clr = 1'b0;
    logic          wake_en = 1'b0;
    logic          wake_global_en = 1'b0;
    logic          run_sts_clr = 1'b0;
    logic          mgmt_en = 1'b0;
    logic          mgmt_pin_en = 1'b0;
    logic [SW-1:0] chan_sel = '0;
    logic          wake_req;
    logic          mgmt_irq_n;
    logic [NC-1:0] irq_chan;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_event_router #(.NUM_EVENTS(NE), .NUM_CHAN(NC)) i_irq_event_router (
        .clk(clk), .rst_n(rst_n),
        .periph_powered(periph_powered), .periph_enabled(periph_enabled),
        .rx_mode(rx_mode), .wake_evt(wake_evt),
        .evt_status(evt_status), .evt_enable(evt_enable),
        .master_irq_en(master_irq_en), .wake_sts_clr(wake_sts_clr),
        .wake_en(wake_en), .wake_global_en(wake_global_en),
        .run_sts_clr(run_sts_clr), .mgmt_en(mgmt_en),
        .mgmt_pin_en(mgmt_pin_en), .chan_sel(chan_sel),
        .wake_req(wake_req), .mgmt_irq_n(mgmt_irq_n), .irq_chan(irq_chan)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
    endtask

    task automatic pulse_run();
        evt_status = 4'b0001;
        evt_enable = 4'b0001;
        master_irq_en = 1'b1;
        tick();
        evt_status = '0;
    endtask

    task automatic clear_all();
        wake_sts_clr = 1'b1;
        run_sts_clr  = 1'b1;
        tick();
        wake_sts_clr = 1'b0;
        run_sts_clr  = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 wake_req", 32'(wake_req), 32'd0);
        check("R1 mgmt_irq_n", 32'(mgmt_irq_n), 32'd1);
        check("R1 irq_chan", 32'(irq_chan), 32'd0);
    endtask

    task automatic t_wake_power();
        wake_en = 1'b1; wake_global_en = 1'b1; rx_mode = 2'b01;
        periph_powered = 1'b0; periph_enabled = 1'b1;
        pulse_wake();
        check("R2 unpowered", 32'(wake_req), 32'd0);
        tick();
        check("R2 unpowered no latch", 32'(wake_req), 32'd0);
        periph_powered = 1'b1; periph_enabled = 1'b0;
        pulse_wake();
        check("R2 disabled", 32'(wake_req), 32'd0);
        tick();
        check("R2 disabled no latch", 32'(wake_req), 32'd0);
        periph_enabled = 1'b1;
        pulse_wake();
        check("R2 qualified", 32'(wake_req), 32'd1);
        clear_all();
        check("R8 wake clear", 32'(wake_req), 32'd0);
    endtask

    task automatic t_wake_modes();
        for (int m = 0; m < 4; m++) begin
            rx_mode = 2'(m);
            pulse_wake();
            tick();
            check("R3 mode", 32'(wake_req), (m == 1 || m == 2) ? 32'd1 : 32'd0);
            clear_all();
        end
        rx_mode = 2'b10;
    endtask

    task automatic t_wake_enables();
        wake_en = 1'b0; wake_global_en = 1'b1;
        pulse_wake();
        check("R4 wake_en off", 32'(wake_req), 32'd0);
        wake_en = 1'b1;
        check("R4 registered", 32'(wake_req), 32'd0);
        tick();
        check("R4 latched shows", 32'(wake_req), 32'd1);
        wake_global_en = 1'b0;
        tick();
        check("R4 global off", 32'(wake_req), 32'd0);
        wake_global_en = 1'b1;
        tick();
        check("R4 global on", 32'(wake_req), 32'd1);
        clear_all();
        check("R4 cleared", 32'(wake_req), 32'd0);
    endtask

    task automatic t_wake_sticky();
        pulse_wake();
        repeat (5) tick();
        check("R8 wake holds", 32'(wake_req), 32'd1);
        wake_evt = 1'b1; wake_sts_clr = 1'b1;
        tick();
        wake_evt = 1'b0; wake_sts_clr = 1'b0;
        check("R8 wake set wins", 32'(wake_req), 32'd1);
        tick();
        check("R8 wake set wins later", 32'(wake_req), 32'd1);
        clear_all();
        check("R8 wake clear only", 32'(wake_req), 32'd0);
    endtask

    task automatic t_run_qual();
        mgmt_en = 1'b1; mgmt_pin_en = 1'b1; chan_sel = 4'd3;
        evt_status = 4'b0010; evt_enable = 4'b0100; master_irq_en = 1'b1;
        tick();
        evt_status = '0;
        tick();
        check("R5 unmatched enable", 32'(mgmt_irq_n), 32'd1);
        check("R5 unmatched chan", 32'(irq_chan), 32'd0);
        evt_status = 4'b0010; evt_enable = 4'b0010; master_irq_en = 1'b0;
        tick();
        evt_status = '0;
        tick();
        check("R5 master off", 32'(mgmt_irq_n), 32'd1);
        check("R5 master off chan", 32'(irq_chan), 32'd0);
        evt_status = 4'b0010; master_irq_en = 1'b1;
        tick();
        evt_status = '0;
        check("R5 event mgmt", 32'(mgmt_irq_n), 32'd0);
        check("R5 event chan", 32'(irq_chan), 32'h0004);
        clear_all();
        check("R5 cleared", 32'(mgmt_irq_n), 32'd1);
    endtask

    task automatic t_mgmt_gating();
        mgmt_en = 1'b0; mgmt_pin_en = 1'b1;
        pulse_run();
        check("R6 mgmt_en off", 32'(mgmt_irq_n), 32'd1);
        mgmt_en = 1'b1; mgmt_pin_en = 1'b0;
        tick();
        check("R6 pin off", 32'(mgmt_irq_n), 32'd1);
        mgmt_pin_en = 1'b1;
        tick();
        check("R6 both on", 32'(mgmt_irq_n), 32'd0);
        clear_all();
        check("R6 cleared", 32'(mgmt_irq_n), 32'd1);
    endtask

    task automatic t_run_sticky();
        pulse_run();
        repeat (4) tick();
        check("R8 run holds", 32'(mgmt_irq_n), 32'd0);
        evt_status = 4'b0001; run_sts_clr = 1'b1;
        tick();
        evt_status = '0; run_sts_clr = 1'b0;
        check("R8 run set wins", 32'(mgmt_irq_n), 32'd0);
        tick();
        check("R8 run set wins later", 32'(mgmt_irq_n), 32'd0);
        clear_all();
        check("R8 run clear only", 32'(mgmt_irq_n), 32'd1);
    endtask

    task automatic t_channels();
        chan_sel = '0;
        pulse_run();
        for (int k = 0; k <= NC; k++) begin
            chan_sel = SW'(k);
            tick();
            check("R7 channel", 32'(irq_chan), (k == 0) ? 32'd0 : (32'd1 << (k - 1)));
            check("R9 mgmt with channel", 32'(mgmt_irq_n), 32'd0);
        end
        clear_all();
        check("R7 cleared", 32'(irq_chan), 32'd0);
        check("R9 cleared", 32'(mgmt_irq_n), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wake_power();
        t_wake_modes();
        t_wake_enables();
        t_wake_sticky();
        t_run_qual();
        t_mgmt_gating();
        t_run_sticky();
        t_channels();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule